// File: doc/BRIEF.md
# Strobe-Latched 256x4 Static Memory

This block is a 256-word by 4-bit static memory that behaves like a bus-friendly RAM with latched inputs. Its storage is a 32-row by 32-column bit matrix. A word is found by a row decoder and a column-group decoder. Reads, writes, select checks and output control all run from one system clock. The enable strobe, write strobe and both selects are active-low pins, and they are sampled on that clock. The block finds the falling edge of the enable strobe by comparing the present sample with the previous one.

On that falling edge the block captures the address and the latched select. The access that follows always uses the captured values, so the address bus may change during the access. While the latched select is active, the access acts as follows:

- With the write strobe low, the word on the data-in bus is stored.
- With the write strobe high, the output latch loads the addressed word.

When the enable strobe returns high, the latch holds its last value and the decoders shut off.

The data-out port is a data/drive-enable pair. A pad or bus stage outside the block turns it into a three-state line. The drive enable needs three things: the latched select active, valid read data in the latch, and the unlatched select active. The unlatched select gates the drive directly, with no register in the path.

Top module: `strobe_ram`

## Requirements
- R1: After reset, `q_en` is 0, `q_data` is 0, and no access is in progress.
- R2: The first clock edge at which `ce_n` is sampled 0 after being sampled 1 captures `addr` and `sel_lat_n`. Changes on these pins after that edge do not alter the access, which runs until `ce_n` is sampled 1.
- R3: At each later edge with `ce_n` still 0, a captured select of 0 and `we_n` = 0, `din` is stored at the captured address. `q_en` stays 0 from the capture edge through the write.
- R4: At each later edge with `ce_n` still 0, a captured select of 0 and `we_n` = 1, the output latch loads the word at the captured address. A new access sets `q_en` to 0 at its capture edge, and it stays 0 until the first read edge.
- R5: `q_en` is 1 only when all of the following hold: the latched select is active, the latch holds read data, and `sel_out_n` is 0. `sel_out_n` acts on `q_en` with no clock delay. An access whose captured select is 1 neither reads nor writes.
- R6: While `ce_n` is sampled 1, no write occurs whatever `we_n`, `addr` and `din` do. In that state `q_data` keeps the last word read.
- R7: Address bits {7,6,5,1,0} select one of 32 rows and bits {4,3,2} select a column group. Data bit i of a word sits in column i*8 + group, so each of the 256 addresses holds its own word.
- R8: While no access is in progress, the select latch is transparent. A change on `sel_lat_n` reaches `q_en` after one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low enable strobe; its falling edge starts an access |
| we_n | input | 1 | Active-low write strobe |
| sel_lat_n | input | 1 | Active-low select, latched by the enable strobe |
| sel_out_n | input | 1 | Active-low select that gates output drive directly |
| addr | input | 8 | Word address |
| din | input | 4 | Write data |
| q_data | output | 4 | Output latch contents |
| q_en | output | 1 | Drive enable for the output; 0 means high impedance |

## Verification
Counting from the first rising edge that samples `ce_n` low, the address is captured at that edge and the read or write takes place one edge later. Read data and its drive enable therefore become visible after the second edge. The bench drives on falling edges and checks on the falling edge after the edge that produces each result. One sample falls between capture and operation, where `q_en` must already be 0. A change on `sel_out_n` is checked one time unit after it is driven, with no clock edge in between. A change on `sel_lat_n` while idle is checked after exactly one edge. The bench also changes the address right after the capture edge, so that an access using the wrong address is caught against the bench's reference array.

// File: rtl/srl_pkg.sv
package srl_pkg;
   // operation performed at a clock edge
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } ram_op_e;
endpackage

// File: rtl/ram_strobe_ctrl.sv
module ram_strobe_ctrl
   import srl_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              sel_lat_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              fall,
   output logic              acc,
   output logic [ADDR_W-1:0] addr_lat,
   output logic              sel_ok,
   output ram_op_e           op
);
   logic ce_prev;

   // strobe falling edge: previous sample high, present sample low
   assign fall = ce_prev & ~ce_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_prev  <= 1'b1;
         acc      <= 1'b0;
         addr_lat <= '0;
         sel_ok   <= 1'b0;
      end else begin
         ce_prev <= ce_n;
         acc     <= ~ce_n & (acc | fall);
         if (fall) begin
            addr_lat <= addr;
         end
         // select latch: follows the pin while idle, frozen during access
         if (ce_n || fall) begin
            sel_ok <= ~sel_lat_n;
         end
      end
   end

   always_comb begin
      op = OP_NONE;
      if (acc && !ce_n && sel_ok) begin
         op = we_n ? OP_READ : OP_WRITE;
      end
   end
endmodule

// File: rtl/ram_decode.sv
module ram_decode #(
   parameter int ADDR_W   = 8,
   parameter int ROWS     = 32,
   parameter int COL_AW   = 3,
   parameter int ROW_LO_W = 2
) (
   input  logic [ADDR_W-1:0] addr_lat,
   input  logic              en,
   output logic [ROWS-1:0]   row_sel,
   output logic [COL_AW-1:0] col_grp
);
   localparam int ROW_AW   = $clog2(ROWS);
   localparam int ROW_HI_W = ROW_AW - ROW_LO_W;

   logic [ROW_AW-1:0] row_idx;

   // row index built from the low field and the high field of the address
   generate
      if (ROW_LO_W == 0) begin : g_row_hi_only
         assign row_idx = addr_lat[ADDR_W-1 -: ROW_AW];
      end else if (ROW_HI_W == 0) begin : g_row_lo_only
         assign row_idx = addr_lat[ROW_AW-1:0];
      end else begin : g_row_split
         assign row_idx = {addr_lat[ADDR_W-1 -: ROW_HI_W], addr_lat[ROW_LO_W-1:0]};
      end
   endgenerate

   assign col_grp = addr_lat[ROW_LO_W +: COL_AW];

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row_dec
         assign row_sel[r] = en && (row_idx == ROW_AW'(r));
      end
   endgenerate
endmodule

// File: rtl/ram_bit_matrix.sv
module ram_bit_matrix #(
   parameter int ROWS   = 32,
   parameter int COLS   = 32,
   parameter int WORD_W = 4
) (
   input  logic                           clk,
   input  logic                           we,
   input  logic [ROWS-1:0]                row_sel,
   input  logic [$clog2(COLS/WORD_W)-1:0] col_grp,
   input  logic [WORD_W-1:0]              din,
   output logic [WORD_W-1:0]              rd_word
);
   localparam int GRPS   = COLS / WORD_W;
   localparam int COL_AW = $clog2(GRPS);

   logic [COLS-1:0] cells [ROWS];
   logic [COLS-1:0] row_word;

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         always_ff @(posedge clk) begin
            if (we && row_sel[r]) begin
               for (int c = 0; c < COLS; c++) begin
                  if (col_grp == COL_AW'(c % GRPS)) begin
                     cells[r][c] <= din[c / GRPS];
                  end
               end
            end
         end
      end
   endgenerate

   // and-or row mux, then column-group pick per data bit
   always_comb begin
      row_word = '0;
      for (int r = 0; r < ROWS; r++) begin
         if (row_sel[r]) begin
            row_word = row_word | cells[r];
         end
      end
      for (int i = 0; i < WORD_W; i++) begin
         rd_word[i] = row_word[i*GRPS + int'(col_grp)];
      end
   end
endmodule

// File: rtl/ram_out_latch.sv
module ram_out_latch
   import srl_pkg::*;
#(
   parameter int WORD_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall,
   input  ram_op_e           op,
   input  logic [WORD_W-1:0] rd_word,
   input  logic              sel_ok,
   input  logic              sel_out_n,
   output logic [WORD_W-1:0] q_data,
   output logic              q_en
);
   logic rd_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_data   <= '0;
         rd_valid <= 1'b0;
      end else if (op == OP_READ) begin
         q_data   <= rd_word;
         rd_valid <= 1'b1;
      end else if (fall || op == OP_WRITE) begin
         rd_valid <= 1'b0;
      end
   end

   assign q_en = rd_valid & sel_ok & ~sel_out_n;
endmodule

// File: rtl/strobe_ram.sv
module strobe_ram
   import srl_pkg::*;
#(
   parameter  int WORD_W   = 4,
   parameter  int ROWS     = 32,
   parameter  int COLS     = 32,
   parameter  int ROW_LO_W = 2,
   localparam int GRPS     = COLS / WORD_W,
   localparam int COL_AW   = $clog2(GRPS),
   localparam int ROW_AW   = $clog2(ROWS),
   localparam int ADDR_W   = ROW_AW + COL_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              sel_lat_n,
   input  logic              sel_out_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] q_data,
   output logic              q_en
);
   generate
      if (COLS % WORD_W != 0) begin : g_bad_cols
         $error("COLS must be a multiple of WORD_W");
      end
      if ((1 << ROW_AW) != ROWS) begin : g_bad_rows
         $error("ROWS must be a power of two");
      end
      if ((1 << COL_AW) != GRPS) begin : g_bad_grps
         $error("COLS/WORD_W must be a power of two");
      end
      if (ROW_LO_W > ROW_AW) begin : g_bad_split
         $error("ROW_LO_W exceeds row address width");
      end
   endgenerate

   logic              fall;
   logic              acc;
   logic [ADDR_W-1:0] addr_lat;
   logic              sel_ok;
   ram_op_e           op;
   logic [ROWS-1:0]   row_sel;
   logic [COL_AW-1:0] col_grp;
   logic [WORD_W-1:0] rd_word;
   logic              mem_we;

   ram_strobe_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_n      (ce_n),
      .we_n      (we_n),
      .sel_lat_n (sel_lat_n),
      .addr      (addr),
      .fall      (fall),
      .acc       (acc),
      .addr_lat  (addr_lat),
      .sel_ok    (sel_ok),
      .op        (op)
   );

   ram_decode #(
      .ADDR_W   (ADDR_W),
      .ROWS     (ROWS),
      .COL_AW   (COL_AW),
      .ROW_LO_W (ROW_LO_W)
   ) u_dec (
      .addr_lat (addr_lat),
      .en       (acc),
      .row_sel  (row_sel),
      .col_grp  (col_grp)
   );

   assign mem_we = (op == OP_WRITE);

   ram_bit_matrix #(
      .ROWS   (ROWS),
      .COLS   (COLS),
      .WORD_W (WORD_W)
   ) u_mat (
      .clk     (clk),
      .we      (mem_we),
      .row_sel (row_sel),
      .col_grp (col_grp),
      .din     (din),
      .rd_word (rd_word)
   );

   ram_out_latch #(.WORD_W(WORD_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall      (fall),
      .op        (op),
      .rd_word   (rd_word),
      .sel_ok    (sel_ok),
      .sel_out_n (sel_out_n),
      .q_data    (q_data),
      .q_en      (q_en)
   );
endmodule

// File: rtl/strobe_ram_sva.sv
module strobe_ram_sva #(
   parameter int ADDR_W = 8,
   parameter int ROWS   = 32,
   parameter int WORD_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              sel_out_n,
   input logic              fall,
   input logic              acc,
   input logic [ADDR_W-1:0] addr_lat,
   input logic              mem_we,
   input logic [ROWS-1:0]   row_sel,
   input logic [WORD_W-1:0] q_data,
   input logic              q_en
);
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !ce_n) |=> $stable(addr_lat)); // R2

   AST_WRITE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !q_en); // R3

   AST_FALL_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !q_en); // R4

   AST_SELOUT_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
      sel_out_n |-> !q_en); // R5

   AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |-> !mem_we); // R6

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> $stable(q_data)); // R6

   AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      acc |-> $onehot(row_sel)); // R7

   AST_ROW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |-> (row_sel == '0)); // R7
endmodule

bind strobe_ram strobe_ram_sva #(
   .ADDR_W (ADDR_W),
   .ROWS   (ROWS),
   .WORD_W (WORD_W)
) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce_n      (ce_n),
   .sel_out_n (sel_out_n),
   .fall      (fall),
   .acc       (acc),
   .addr_lat  (addr_lat),
   .mem_we    (mem_we),
   .row_sel   (row_sel),
   .q_data    (q_data),
   .q_en      (q_en)
);

// File: tb/strobe_ram_tb.sv
module strobe_ram_tb;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce_n = 1'b1;
   logic       we_n = 1'b1;
   logic       sel_lat_n = 1'b1;
   logic       sel_out_n = 1'b1;
   logic [7:0] addr = '0;
   logic [3:0] din = '0;
   logic [3:0] q_data;
   logic       q_en;

   int n_tests = 0;
   int n_fail  = 0;
   logic [3:0] mirror [256];

   always #(CLK_P/2) clk = ~clk;

   strobe_ram u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_n      (ce_n),
      .we_n      (we_n),
      .sel_lat_n (sel_lat_n),
      .sel_out_n (sel_out_n),
      .addr      (addr),
      .din       (din),
      .q_data    (q_data),
      .q_en      (q_en)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // write access; the address bus changes right after capture (R2)
   task automatic wr(input logic [7:0] a, input logic [3:0] d);
      @(negedge clk);
      addr = a; din = d; we_n = 1'b0; sel_lat_n = 1'b0; ce_n = 1'b0;
      @(negedge clk);
      chk("R3", "q_en after capture", q_en, 0);
      addr = ~a;
      @(negedge clk);
      chk("R3", "q_en during write", q_en, 0);
      ce_n = 1'b1; we_n = 1'b1;
      mirror[a] = d;
   endtask

   // read access; leaves the block idle with the latch holding the word
   task automatic rd(input logic [7:0] a, input string req);
      @(negedge clk);
      addr = a; we_n = 1'b1; sel_lat_n = 1'b0; sel_out_n = 1'b0; ce_n = 1'b0;
      @(negedge clk);
      chk("R4", "q_en before read edge", q_en, 0);
      addr = a ^ 8'h5A;
      @(negedge clk);
      chk(req, $sformatf("read data @%02h", a), q_data, mirror[a]);
      chk(req, "q_en on read", q_en, 1);
      ce_n = 1'b1;
      @(negedge clk);
      chk("R6", "frozen data after strobe", q_data, mirror[a]);
   endtask

   task automatic t_reset();
      chk("R1", "q_en at reset", q_en, 0);
      chk("R1", "q_data at reset", q_data, 0);
   endtask

   task automatic t_basic();
      wr(8'h00, 4'h5);
      wr(8'hFF, 4'hA);
      wr(8'h3C, 4'h9);
      rd(8'h00, "R2");
      rd(8'hFF, "R4");
      rd(8'h3C, "R3");
   endtask

   task automatic t_sweep();
      for (int p = 0; p < 2; p++) begin
         for (int a = 0; a < 256; a++) begin
            wr(8'(a), 4'((a ^ (a >> 3) ^ (a >> 6) ^ (p * 4'hB))));
         end
         for (int a = 0; a < 256; a++) begin
            rd(8'(a), "R7");
         end
      end
   endtask

   task automatic t_selout();
      @(negedge clk);
      addr = 8'h3C; we_n = 1'b1; sel_lat_n = 1'b0; sel_out_n = 1'b1; ce_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R5", "q_en with unlatched select off", q_en, 0);
      sel_out_n = 1'b0;
      #1;
      chk("R5", "q_en follows unlatched select", q_en, 1);
      chk("R5", "data under unlatched select", q_data, mirror[8'h3C]);
      sel_out_n = 1'b1;
      #1;
      chk("R5", "q_en drops with unlatched select", q_en, 0);
      ce_n = 1'b1; sel_out_n = 1'b0;
   endtask

   task automatic t_unselected();
      @(negedge clk);
      addr = 8'h11; din = ~mirror[8'h11]; we_n = 1'b0; sel_lat_n = 1'b1; ce_n = 1'b0;
      @(negedge clk);
      sel_lat_n = 1'b0;   // select rises only after capture: must stay ignored
      @(negedge clk);
      chk("R5", "q_en in unselected access", q_en, 0);
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1;
      rd(8'h11, "R5");
   endtask

   task automatic t_idle_we();
      rd(8'hFF, "R4");
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         addr = 8'h22; din = 4'(k + 3); we_n = k[0];
      end
      @(negedge clk);
      we_n = 1'b1;
      chk("R6", "q_data held while idle", q_data, mirror[8'hFF]);
      chk("R6", "q_en held while idle", q_en, 1);
      rd(8'h22, "R6");
   endtask

   task automatic t_sel_latch();
      rd(8'h00, "R4");
      sel_lat_n = 1'b1;
      @(negedge clk);
      chk("R8", "q_en after idle select off", q_en, 0);
      sel_lat_n = 1'b0;
      @(negedge clk);
      chk("R8", "q_en after idle select on", q_en, 1);
      // select held through an access even if the pin goes inactive
      @(negedge clk);
      addr = 8'hFF; we_n = 1'b1; ce_n = 1'b0;
      @(negedge clk);
      sel_lat_n = 1'b1;
      @(negedge clk);
      chk("R2", "latched select held", q_en, 1);
      chk("R2", "data with held select", q_data, mirror[8'hFF]);
      ce_n = 1'b1;
      @(negedge clk);
      chk("R8", "select follows pin once idle", q_en, 0);
      sel_lat_n = 1'b0;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int a = 0; a < 256; a++) mirror[a] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_sweep();
      t_selout();
      t_unselected();
      t_idle_we();
      t_sel_latch();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule